// File: doc/BRIEF.md
# Secondary Core Bring-Up Sequencer

This block takes a request to start one secondary core of a multi-cluster processor complex and turns it into a fixed series of register-level actions on that core's reset, debug and trace controls. The request carries an affinity value and the address the core should start from. The block turns the affinity value into a dense core index. It rejects cores in clusters it cannot start. For an accepted core it records the start address in a small per-core table and publishes a shared trampoline address. It then walks the target core through reset, debug lock and trace reset, hands the power-up to an external clamp sequencer, and releases everything in a set order.

All reset-type outputs are active low: a 0 holds the core in that reset or keeps its debug port locked, and a 1 releases it. Each register action takes exactly one clock cycle, so the timing of every step after acceptance is fixed, except for the wait on the clamp sequencer. A response strobe ends every accepted request with a status code. While a sequence runs, the ready output is low and new requests wait.

Top module: `core_wake_sequencer`

## Requirements
- R1: The dense index is `{affinity[8], affinity[1:0]}`, which gives 0..3 for cluster 0 and 4..7 for cluster 1. The other affinity bits have no effect. The index of the accepted core appears on `pwr_core`.
- R2: A request whose affinity bit 8 is 1 is answered on the next cycle with `rsp_valid`=1 and `rsp_status`=2'b10. It changes no reset, debug, L1 or entry output, and it writes no entry table slot.
- R3: The start address of an accepted request is written into the table slot for its dense index one cycle after acceptance. In the same cycle `sec_entry` takes the value of `SEC_ENTRY_ADDR`, before any reset output moves. A table slot is read by placing its index on `entry_rd_id`, and the data appears on `entry_rd_data` one cycle later.
- R4: After a synchronous reset, `por_n`, `trace_rst_n`, `dbg_open` and `l1_rst_dis` are all ones. `core_rst_n` and `sec_entry` are zero, `req_ready` is 1, and `rsp_valid` and `pwr_start` are 0.
- R5: Counting from the acceptance edge as edge 0, the target bit is cleared in four steps. `por_n` clears at edge 2. `l1_rst_dis` clears at edge 3 and stays cleared. `dbg_open` clears at edge 4 and `trace_rst_n` clears at edge 5. The bits of all other cores do not change.
- R6: `pwr_start` is high for exactly the one cycle after edge 6. The block then waits any number of cycles for `pwr_done`, and no output changes while it waits.
- R7: Call P the edge at which `pwr_done` is sampled high. The target bit of `por_n` is released at edge P+1, `core_rst_n` at P+2, `trace_rst_n` at P+3 and `dbg_open` at P+4.
- R8: A completed sequence gives `rsp_valid`=1 with `rsp_status`=2'b00 for exactly one cycle, in the same cycle as the debug unlock.
- R9: `req_ready` is low from the cycle after acceptance until the debug unlock. A request presented in that interval is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core start request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_affinity | input | AFF_W | Affinity value of the target core |
| req_entry | input | ADDR_W | Start address for the target core |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 = success, 2 = invalid target |
| pwr_start | output | 1 | One-cycle start pulse to the power clamp sequencer |
| pwr_core | output | ID_W | Dense index of the core being started |
| pwr_done | input | 1 | Power clamp sequence finished |
| sec_entry | output | ADDR_W | Shared secondary entry address |
| por_n | output | N | Power-on reset per core, active low |
| core_rst_n | output | N | Core reset per core, active low |
| trace_rst_n | output | N | Trace unit reset per core, active low |
| dbg_open | output | N | External debug access per core, 0 = locked |
| l1_rst_dis | output | N | L1 reset-disable control per core |
| entry_rd_id | input | ID_W | Entry table read index |
| entry_rd_data | output | ADDR_W | Entry table read data, one cycle latency |

## Verification
The sequencer sets a fixed cycle for every step, so a wrong state shows up at once as a reset, debug or trace bit that moves one cycle early or late, or on the wrong core. The bench compares every output against its expected value on every cycle of every sequence. A state that skips the power wait releases `por_n` before `pwr_done`, and this shows at the first cycle after the start pulse. A wrong affinity decode shows on `pwr_core` and in the entry table read-back, both a few cycles after the request. A bad rejection path shows as a moved output or a wrong status on the next cycle.

// File: rtl/cws_pkg.sv
package cws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE,
    ST_POR_SET,
    ST_L1_CLR,
    ST_DBG_LOCK,
    ST_TRC_SET,
    ST_PWR_GO,
    ST_PWR_WAIT,
    ST_POR_REL,
    ST_CORE_REL,
    ST_TRC_REL,
    ST_DBG_OPEN
  } step_e;

  localparam logic [1:0] RSP_OK    = 2'b00;
  localparam logic [1:0] RSP_INVAL = 2'b10;

endpackage

// File: rtl/cws_affinity_decode.sv
module cws_affinity_decode #(
  parameter int AFF_W              = 24,
  parameter int CORE_W             = 2,
  parameter int CL_W               = 1,
  parameter int CLUSTER_LSB        = 8,
  parameter int SUPPORTED_CLUSTERS = 1,
  parameter int LITTLE_CLUSTERS    = 1,
  localparam int ID_W              = CL_W + CORE_W
) (
  input  logic [AFF_W-1:0] affinity,
  output logic [ID_W-1:0]  dense_id,
  output logic             supported,
  output logic             little
);

  logic [CORE_W-1:0] core_f;
  logic [CL_W-1:0]   cl_f;

  always_comb begin
    core_f    = affinity[CORE_W-1:0];
    cl_f      = affinity[CLUSTER_LSB +: CL_W];
    dense_id  = {cl_f, core_f};
    supported = (32'(cl_f) < SUPPORTED_CLUSTERS);
    little    = (32'(cl_f) < LITTLE_CLUSTERS);
  end

endmodule

// File: rtl/cws_entry_store.sv
module cws_entry_store #(
  parameter int N      = 8,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ID_W-1:0]   waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ID_W-1:0]   raddr,
  output logic [ADDR_W-1:0] rdata
);

  logic [ADDR_W-1:0] mem [N];

  initial begin
    for (int k = 0; k < N; k++) mem[k] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cws_ctrl.sv
module cws_ctrl
  import cws_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   dec_id,
  input  logic              dec_supported,
  input  logic              dec_little,
  input  logic [ADDR_W-1:0] req_entry,
  input  logic              pwr_done,
  output logic              req_ready,
  output step_e             step,
  output logic [ID_W-1:0]   tgt_id,
  output logic              tgt_little,
  output logic [ADDR_W-1:0] tgt_entry,
  output logic              pwr_start,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status
);

  step_e nxt;
  logic  take;

  assign req_ready = (step == ST_IDLE);
  assign take      = req_valid && req_ready;

  always_comb begin
    nxt = step;
    unique case (step)
      ST_IDLE:     if (take && dec_supported) nxt = ST_SAVE;
      ST_SAVE:     nxt = ST_POR_SET;
      ST_POR_SET:  nxt = ST_L1_CLR;
      ST_L1_CLR:   nxt = ST_DBG_LOCK;
      ST_DBG_LOCK: nxt = ST_TRC_SET;
      ST_TRC_SET:  nxt = ST_PWR_GO;
      ST_PWR_GO:   nxt = ST_PWR_WAIT;
      ST_PWR_WAIT: if (pwr_done) nxt = ST_POR_REL;
      ST_POR_REL:  nxt = ST_CORE_REL;
      ST_CORE_REL: nxt = ST_TRC_REL;
      ST_TRC_REL:  nxt = ST_DBG_OPEN;
      ST_DBG_OPEN: nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= ST_IDLE;
      tgt_id     <= '0;
      tgt_little <= 1'b0;
      tgt_entry  <= '0;
      pwr_start  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_OK;
    end else begin
      step      <= nxt;
      pwr_start <= (step == ST_PWR_GO);
      rsp_valid <= 1'b0;
      if (take) begin
        if (dec_supported) begin
          tgt_id     <= dec_id;
          tgt_little <= dec_little;
          tgt_entry  <= req_entry;
        end else begin
          rsp_valid  <= 1'b1;
          rsp_status <= RSP_INVAL;
        end
      end
      if (step == ST_DBG_OPEN) begin
        rsp_valid  <= 1'b1;
        rsp_status <= RSP_OK;
      end
    end
  end

endmodule

// File: rtl/cws_reset_bank.sv
module cws_reset_bank
  import cws_pkg::*;
#(
  parameter int                N              = 8,
  parameter int                ID_W           = 3,
  parameter int                ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] SEC_ENTRY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic [ID_W-1:0]   tgt_id,
  input  logic              tgt_little,
  output logic [N-1:0]      por_n,
  output logic [N-1:0]      core_rst_n,
  output logic [N-1:0]      trace_rst_n,
  output logic [N-1:0]      dbg_open,
  output logic [N-1:0]      l1_rst_dis,
  output logic [ADDR_W-1:0] sec_entry
);

  always_ff @(posedge clk) begin
    if (rst) sec_entry <= '0;
    else if (step == ST_SAVE) sec_entry <= SEC_ENTRY_ADDR;
  end

  for (genvar i = 0; i < N; i++) begin : g_core
    logic hit;
    assign hit = (tgt_id == ID_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        por_n[i]       <= 1'b1;
        core_rst_n[i]  <= 1'b0;
        trace_rst_n[i] <= 1'b1;
        dbg_open[i]    <= 1'b1;
        l1_rst_dis[i]  <= 1'b1;
      end else if (hit) begin
        unique case (step)
          ST_POR_SET:  por_n[i]       <= 1'b0;
          ST_L1_CLR:   if (tgt_little) l1_rst_dis[i]  <= 1'b0;
          ST_DBG_LOCK: dbg_open[i]    <= 1'b0;
          ST_TRC_SET:  if (tgt_little) trace_rst_n[i] <= 1'b0;
          ST_POR_REL:  por_n[i]       <= 1'b1;
          ST_CORE_REL: core_rst_n[i]  <= 1'b1;
          ST_TRC_REL:  if (tgt_little) trace_rst_n[i] <= 1'b1;
          ST_DBG_OPEN: dbg_open[i]    <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/core_wake_sequencer.sv
module core_wake_sequencer
  import cws_pkg::*;
#(
  parameter int                CORES_PER_CLUSTER  = 4,
  parameter int                CLUSTERS           = 2,
  parameter int                AFF_W              = 24,
  parameter int                ADDR_W             = 32,
  parameter int                CLUSTER_LSB        = 8,
  parameter int                SUPPORTED_CLUSTERS = 1,
  parameter int                LITTLE_CLUSTERS    = 1,
  parameter logic [ADDR_W-1:0] SEC_ENTRY_ADDR     = 'h100,
  localparam int               CORE_W             = $clog2(CORES_PER_CLUSTER),
  localparam int               CL_W               = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1,
  localparam int               ID_W               = CL_W + CORE_W,
  localparam int               N                  = CLUSTERS * CORES_PER_CLUSTER
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AFF_W-1:0]  req_affinity,
  input  logic [ADDR_W-1:0] req_entry,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              pwr_start,
  output logic [ID_W-1:0]   pwr_core,
  input  logic              pwr_done,
  output logic [ADDR_W-1:0] sec_entry,
  output logic [N-1:0]      por_n,
  output logic [N-1:0]      core_rst_n,
  output logic [N-1:0]      trace_rst_n,
  output logic [N-1:0]      dbg_open,
  output logic [N-1:0]      l1_rst_dis,
  input  logic [ID_W-1:0]   entry_rd_id,
  output logic [ADDR_W-1:0] entry_rd_data
);

  logic [ID_W-1:0]   dec_id;
  logic              dec_supported;
  logic              dec_little;
  step_e             step;
  logic [ID_W-1:0]   tgt_id;
  logic              tgt_little;
  logic [ADDR_W-1:0] tgt_entry;

  cws_affinity_decode #(
    .AFF_W(AFF_W), .CORE_W(CORE_W), .CL_W(CL_W), .CLUSTER_LSB(CLUSTER_LSB),
    .SUPPORTED_CLUSTERS(SUPPORTED_CLUSTERS), .LITTLE_CLUSTERS(LITTLE_CLUSTERS)
  ) u_dec (
    .affinity (req_affinity),
    .dense_id (dec_id),
    .supported(dec_supported),
    .little   (dec_little)
  );

  cws_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .dec_id       (dec_id),
    .dec_supported(dec_supported),
    .dec_little   (dec_little),
    .req_entry    (req_entry),
    .pwr_done     (pwr_done),
    .req_ready    (req_ready),
    .step         (step),
    .tgt_id       (tgt_id),
    .tgt_little   (tgt_little),
    .tgt_entry    (tgt_entry),
    .pwr_start    (pwr_start),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status)
  );

  cws_reset_bank #(
    .N(N), .ID_W(ID_W), .ADDR_W(ADDR_W), .SEC_ENTRY_ADDR(SEC_ENTRY_ADDR)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .tgt_id     (tgt_id),
    .tgt_little (tgt_little),
    .por_n      (por_n),
    .core_rst_n (core_rst_n),
    .trace_rst_n(trace_rst_n),
    .dbg_open   (dbg_open),
    .l1_rst_dis (l1_rst_dis),
    .sec_entry  (sec_entry)
  );

  cws_entry_store #(.N(N), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .we   (step == ST_SAVE),
    .waddr(tgt_id),
    .wdata(tgt_entry),
    .raddr(entry_rd_id),
    .rdata(entry_rd_data)
  );

  assign pwr_core = tgt_id;

endmodule

// File: rtl/cws_checker.sv
module cws_checker #(
  parameter int                N         = 8,
  parameter int                FIXED_LO  = 4,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] SEC_ADDR  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              pwr_start,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sec_entry,
  input logic [N-1:0]      por_n,
  input logic [N-1:0]      core_rst_n,
  input logic [N-1:0]      trace_rst_n,
  input logic [N-1:0]      dbg_open
);

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    pwr_start |=> !pwr_start);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    pwr_start |-> !req_ready);

  a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r3_trampoline_first: assert property (@(posedge clk) disable iff (rst)
      $fell(por_n[i]) |-> (sec_entry == SEC_ADDR));

    a_r5_lock_before_trace: assert property (@(posedge clk) disable iff (rst)
      $fell(trace_rst_n[i]) |-> !dbg_open[i]);

    a_r7_por_before_core: assert property (@(posedge clk) disable iff (rst)
      $rose(core_rst_n[i]) |-> por_n[i]);

    a_r7_trace_before_unlock: assert property (@(posedge clk) disable iff (rst)
      $rose(dbg_open[i]) |-> (trace_rst_n[i] && core_rst_n[i]));

    if (i >= FIXED_LO) begin : g_fixed
      a_r2_rejected_stable: assert property (@(posedge clk) disable iff (rst)
        ##1 ($stable(por_n[i]) && $stable(core_rst_n[i]) &&
             $stable(trace_rst_n[i]) && $stable(dbg_open[i])));
    end
  end

endmodule

bind core_wake_sequencer cws_checker #(
  .N(N), .FIXED_LO(SUPPORTED_CLUSTERS * CORES_PER_CLUSTER),
  .ADDR_W(ADDR_W), .SEC_ADDR(SEC_ENTRY_ADDR)
) u_cws_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .pwr_start  (pwr_start),
  .rsp_valid  (rsp_valid),
  .sec_entry  (sec_entry),
  .por_n      (por_n),
  .core_rst_n (core_rst_n),
  .trace_rst_n(trace_rst_n),
  .dbg_open   (dbg_open)
);

// File: tb/tb_core_wake_sequencer.sv
`timescale 1ns/1ps
module tb_core_wake_sequencer;

  localparam int          AFF_W  = 24;
  localparam int          ADDR_W = 32;
  localparam int          N      = 8;
  localparam int          ID_W   = 3;
  localparam logic [31:0] TRAMP  = 32'h0000_0100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [AFF_W-1:0]  req_affinity = '0;
  logic [ADDR_W-1:0] req_entry = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_status;
  logic              pwr_start;
  logic [ID_W-1:0]   pwr_core;
  logic              pwr_done = 1'b0;
  logic [ADDR_W-1:0] sec_entry;
  logic [N-1:0]      por_n, core_rst_n, trace_rst_n, dbg_open, l1_rst_dis;
  logic [ID_W-1:0]   entry_rd_id = '0;
  logic [ADDR_W-1:0] entry_rd_data;

  core_wake_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_affinity(req_affinity), .req_entry(req_entry),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .pwr_start(pwr_start), .pwr_core(pwr_core), .pwr_done(pwr_done),
    .sec_entry(sec_entry), .por_n(por_n), .core_rst_n(core_rst_n),
    .trace_rst_n(trace_rst_n), .dbg_open(dbg_open), .l1_rst_dis(l1_rst_dis),
    .entry_rd_id(entry_rd_id), .entry_rd_data(entry_rd_data)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [N-1:0]      m_por, m_core, m_trc, m_dbg, m_l1;
  logic [ADDR_W-1:0] m_sec;
  logic [ADDR_W-1:0] m_entry [N];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] put(input logic [N-1:0] v, input int i,
                                       input logic b);
    logic [N-1:0] r = v;
    r[i] = b;
    return r;
  endfunction

  function automatic int dense_of(input logic [AFF_W-1:0] a);
    return {29'd0, a[8], a[1:0]};
  endfunction

  task automatic check_quiet(input string req);
    chk(req, "por_n", 64'(por_n), 64'(m_por));
    chk(req, "core_rst_n", 64'(core_rst_n), 64'(m_core));
    chk(req, "trace_rst_n", 64'(trace_rst_n), 64'(m_trc));
    chk(req, "dbg_open", 64'(dbg_open), 64'(m_dbg));
    chk(req, "l1_rst_dis", 64'(l1_rst_dis), 64'(m_l1));
    chk(req, "sec_entry", 64'(sec_entry), 64'(m_sec));
  endtask

  task automatic read_entry(input int id);
    @(negedge clk);
    entry_rd_id = ID_W'(id);
    @(negedge clk);
    chk("R3", $sformatf("entry slot %0d", id), 64'(entry_rd_data), 64'(m_entry[id]));
  endtask

  task automatic do_req(input logic [AFF_W-1:0] aff, input logic [ADDR_W-1:0] ent,
                        input int dly);
    int i = dense_of(aff);
    int p = 7 + dly;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_affinity = aff;
    req_entry = ent;
    @(negedge clk);
    if (aff[8]) begin
      req_valid = 1'b0;
      chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R2", "rsp_status", 64'(rsp_status), 64'd2);
      chk("R2", "req_ready", 64'(req_ready), 64'd1);
      chk("R2", "pwr_start", 64'(pwr_start), 64'd0);
      check_quiet("R2");
      @(negedge clk);
      chk("R2", "rsp_valid drop", 64'(rsp_valid), 64'd0);
      check_quiet("R2");
      read_entry(i);
      return;
    end
    // t = 0: keep a foreign request on the bus while busy (R9)
    req_affinity = {aff[AFF_W-1:2], ~aff[1:0]};
    req_entry = ~ent;
    for (int t = 0; t <= p + 5; t++) begin
      if (t > 0) @(negedge clk);
      chk("R5", "por_n", 64'(por_n),
          64'((t >= 2 && t <= p) ? put(m_por, i, 1'b0) : put(m_por, i, 1'b1)));
      chk("R5", "l1_rst_dis", 64'(l1_rst_dis),
          64'((t >= 3) ? put(m_l1, i, 1'b0) : m_l1));
      chk("R5", "dbg_open", 64'(dbg_open),
          64'((t >= 4 && t <= p + 3) ? put(m_dbg, i, 1'b0) : put(m_dbg, i, 1'b1)));
      chk("R7", "trace_rst_n", 64'(trace_rst_n),
          64'((t >= 5 && t <= p + 2) ? put(m_trc, i, 1'b0) : put(m_trc, i, 1'b1)));
      chk("R7", "core_rst_n", 64'(core_rst_n),
          64'((t >= p + 2) ? put(m_core, i, 1'b1) : m_core));
      chk("R3", "sec_entry", 64'(sec_entry), 64'((t >= 1) ? TRAMP : m_sec));
      chk("R6", "pwr_start", 64'(pwr_start), 64'(t == 6));
      chk("R8", "rsp_valid", 64'(rsp_valid), 64'(t == p + 4));
      if (t == p + 4) chk("R8", "rsp_status", 64'(rsp_status), 64'd0);
      chk("R9", "req_ready", 64'(req_ready), 64'(t >= p + 4));
      if (t == 6) chk("R1", "pwr_core", 64'(pwr_core), 64'(i));
      if (t == p) req_valid = 1'b0;
      pwr_done = (t == 6 + dly);
    end
    pwr_done = 1'b0;
    m_por[i] = 1'b1; m_core[i] = 1'b1; m_trc[i] = 1'b1; m_dbg[i] = 1'b1;
    m_l1[i] = 1'b0; m_sec = TRAMP; m_entry[i] = ent;
    read_entry(i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1A2B3C4D));
    m_por = '1; m_core = '0; m_trc = '1; m_dbg = '1; m_l1 = '1; m_sec = '0;
    for (int k = 0; k < N; k++) m_entry[k] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R4");
    chk("R4", "req_ready", 64'(req_ready), 64'd1);
    chk("R4", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R4", "pwr_start", 64'(pwr_start), 64'd0);

    do_req(24'h000000, 32'h8000_0000, 1);
    do_req(24'h000003, 32'h8000_1230, 20);
    do_req(24'h000102, 32'hDEAD_BEEF, 1);
    do_req(24'h000000, 32'h8000_4440, 3);
    do_req(24'hFFFEFD, 32'h1234_5678, 2);
    do_req(24'h000101, 32'h0BAD_0BAD, 1);

    for (int k = 0; k < 40; k++) begin
      logic [AFF_W-1:0] a = AFF_W'($urandom);
      a[8] = ($urandom_range(3) == 0);
      do_req(a, $urandom, $urandom_range(12, 1));
    end

    for (int k = 0; k < N; k++) read_entry(k);
    @(negedge clk);
    check_quiet("R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule